// File: doc/BRIEF.md
# Compact RV32I Integer ALU

This block is the arithmetic and logic unit of a small RV32I integer core. Its purpose is to use as little FPGA area as possible. It is purely combinational. It takes two 32-bit operands, the 3-bit `funct3` field and instruction bit 30, and returns a 32-bit result in the same cycle. A form flag tells it whether the instruction is register-register or register-immediate.

The block saves area by sharing hardware. A single right-shifting barrel shifter handles every shift. For a left shift, the operand is bit-reversed before the shifter and the output is bit-reversed after it. A single adder handles addition, subtraction and both set-less-than operations. The same adder drives three comparison outputs that a branch unit can use directly, so there is no separate comparator.

Top module: `lean_alu`

## Requirements
- R1: With `funct3`=000, `result` is `opA + opB` modulo 2^32 whenever `altBit` is 0 or `regForm` is 0. In the immediate form, `altBit` has no effect.
- R2: With `funct3`=000, `altBit`=1 and `regForm`=1, `result` is `opA - opB` modulo 2^32.
- R3: `funct3`=100 gives bitwise XOR, 110 gives bitwise OR and 111 gives bitwise AND of the operands. `altBit` has no effect on any of them.
- R4: `funct3`=010 gives 1 when `opA` is below `opB` as signed two's-complement numbers, and 0 otherwise. Bits 31..1 of `result` are zero.
- R5: `funct3`=011 gives 1 when `opA` is below `opB` as unsigned numbers, and 0 otherwise. Bits 31..1 of `result` are zero.
- R6: `funct3`=001 shifts `opA` left by `opB[4:0]` and fills with zeros. `opB[31:5]` and `altBit` have no effect.
- R7: `funct3`=101 shifts `opA` right by `opB[4:0]`. With `altBit`=0 the vacated bits are zero; with `altBit`=1 they are copies of `opA[31]`. `opB[31:5]` has no effect.
- R8: Whenever `funct3` is not 000, the comparison outputs are valid. `lessSigned` reports signed `opA < opB`, `lessUnsigned` reports unsigned `opA < opB`, and `equal` reports `opA == opB`.
- R9: A shift amount of 0 returns `opA` unchanged for all three shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; the low 5 bits are the shift amount |
| funct3 | input | 3 | Operation group |
| altBit | input | 1 | Instruction bit 30: selects subtract or arithmetic right shift |
| regForm | input | 1 | 1 for register-register form, 0 for immediate form |
| result | output | 32 | Operation result |
| lessSigned | output | 1 | Signed opA < opB (valid when funct3 is not 000) |
| lessUnsigned | output | 1 | Unsigned opA < opB (valid when funct3 is not 000) |
| equal | output | 1 | opA == opB (valid when funct3 is not 000) |

## Verification
The block holds no state, so a wrong control decode or a wrong datapath bit shows up at `result` or at the comparison flags in the same cycle the inputs are applied.

Some faults are easy to miss with ordinary values:
- A missing reversal in the left-shift path shows only for nonzero shift amounts.
- A wrong fill bit shows only when `opA[31]` is 1.
- A wrong overflow term in the signed comparison shows only when the two operands have opposite signs and their difference overflows.

The directed cases use 0, 0x80000000, 0xFFFFFFFF and shift amounts of 0 and 31 for exactly that reason.

// File: rtl/lean_alu_pkg.sv
package lean_alu_pkg;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_SLT,
    SEL_SLTU,
    SEL_XOR,
    SEL_OR,
    SEL_AND,
    SEL_SHIFT
  } resSel_e;

  typedef struct packed {
    logic    negateB;     // adder computes A + ~B + 1
    logic    shiftLeft;   // wrap the right shifter in bit reversal
    logic    shiftArith;  // fill vacated bits with the sign
    resSel_e resSel;
  } aluCtrl_t;

endpackage

// File: rtl/lean_alu_ctrl.sv
module lean_alu_ctrl
  import lean_alu_pkg::*;
(
  input  logic [2:0] funct3,
  input  logic       altBit,
  input  logic       regForm,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{negateB: 1'b1, shiftLeft: 1'b0, shiftArith: 1'b0, resSel: SEL_SUM};
    unique case (funct3)
      3'b000: begin
        ctrl.negateB = altBit & regForm;
        ctrl.resSel  = SEL_SUM;
      end
      3'b001: begin
        ctrl.shiftLeft = 1'b1;
        ctrl.resSel    = SEL_SHIFT;
      end
      3'b010: ctrl.resSel = SEL_SLT;
      3'b011: ctrl.resSel = SEL_SLTU;
      3'b100: ctrl.resSel = SEL_XOR;
      3'b101: begin
        ctrl.shiftArith = altBit;
        ctrl.resSel     = SEL_SHIFT;
      end
      3'b110: ctrl.resSel = SEL_OR;
      default: ctrl.resSel = SEL_AND;
    endcase
  end

endmodule

// File: rtl/lean_alu_shifter.sv
module lean_alu_shifter #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amount,
  input  logic             fillBit,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [SHW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k]
      ? {{STEP{fillBit}}, stage[k][WIDTH-1:STEP]}
      : stage[k];
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/lean_alu_datapath.sv
module lean_alu_datapath
  import lean_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             lessSigned,
  output logic             lessUnsigned,
  output logic             equal
);

  function automatic logic [WIDTH-1:0] bitRev(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  // shared adder
  logic [WIDTH-1:0] bMod;
  logic [WIDTH:0]   wide;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             overflow;

  assign bMod     = opB ^ {WIDTH{ctrl.negateB}};
  assign wide     = {1'b0, opA} + {1'b0, bMod} + {{WIDTH{1'b0}}, ctrl.negateB};
  assign sum      = wide[WIDTH-1:0];
  assign carryOut = wide[WIDTH];
  assign overflow = (opA[WIDTH-1] == bMod[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1]);

  assign lessUnsigned = ~carryOut;
  assign lessSigned   = sum[WIDTH-1] ^ overflow;
  assign equal        = (sum == '0);

  // single right shifter
  logic [WIDTH-1:0] shIn;
  logic [WIDTH-1:0] shRaw;
  logic [WIDTH-1:0] shOut;
  logic             fillBit;

  assign fillBit = ctrl.shiftArith & opA[WIDTH-1];
  assign shIn    = ctrl.shiftLeft ? bitRev(opA) : opA;

  lean_alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shifter (
    .din    (shIn),
    .amount (opB[SHW-1:0]),
    .fillBit(fillBit),
    .dout   (shRaw)
  );

  assign shOut = ctrl.shiftLeft ? bitRev(shRaw) : shRaw;

  always_comb begin
    unique case (ctrl.resSel)
      SEL_SUM:  result = sum;
      SEL_SLT:  result = {{(WIDTH-1){1'b0}}, lessSigned};
      SEL_SLTU: result = {{(WIDTH-1){1'b0}}, lessUnsigned};
      SEL_XOR:  result = opA ^ opB;
      SEL_OR:   result = opA | opB;
      SEL_AND:  result = opA & opB;
      default:  result = shOut;
    endcase
  end

endmodule

// File: rtl/lean_alu.sv
module lean_alu
  import lean_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funct3,
  input  logic             altBit,
  input  logic             regForm,
  output logic [WIDTH-1:0] result,
  output logic             lessSigned,
  output logic             lessUnsigned,
  output logic             equal
);

  aluCtrl_t ctrl;

  lean_alu_ctrl u_ctrl (
    .funct3 (funct3),
    .altBit (altBit),
    .regForm(regForm),
    .ctrl   (ctrl)
  );

  lean_alu_datapath #(.WIDTH(WIDTH), .SHW(SHW)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .ctrl        (ctrl),
    .result      (result),
    .lessSigned  (lessSigned),
    .lessUnsigned(lessUnsigned),
    .equal       (equal)
  );

endmodule

// File: rtl/lean_alu_chk.sv
module lean_alu_chk #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       funct3,
  input logic [WIDTH-1:0] result,
  input logic             lessSigned,
  input logic             lessUnsigned,
  input logic             equal
);

  always_comb begin
    // R4
    if (funct3 == 3'b010) slt_bits_chk: assert (result[WIDTH-1:1] == '0);
    // R5
    if (funct3 == 3'b011) sltu_bits_chk: assert (result[WIDTH-1:1] == '0);
    // R8
    if (funct3 != 3'b000 && equal) eq_excl_chk: assert (!lessSigned && !lessUnsigned);
    // R9
    if ((funct3 == 3'b001 || funct3 == 3'b101) && opB[SHW-1:0] == '0)
      zero_shift_chk: assert (result == opA);
    // R6
    if (funct3 == 3'b001) shift_left_chk: assert (result == (opA << opB[SHW-1:0]));
  end

endmodule

bind lean_alu lean_alu_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
  .opA         (opA),
  .opB         (opB),
  .funct3      (funct3),
  .result      (result),
  .lessSigned  (lessSigned),
  .lessUnsigned(lessUnsigned),
  .equal       (equal)
);

// File: tb/lean_alu_bench.sv
module lean_alu_bench;

  logic        clk = 1'b0;
  logic [31:0] opA, opB;
  logic [2:0]  funct3;
  logic        altBit, regForm;
  logic [31:0] result;
  logic        lessSigned, lessUnsigned, equal;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  lean_alu u_lean_alu (
    .opA(opA), .opB(opB), .funct3(funct3), .altBit(altBit), .regForm(regForm),
    .result(result), .lessSigned(lessSigned), .lessUnsigned(lessUnsigned), .equal(equal)
  );

  function automatic logic [31:0] refAlu(input logic [31:0] a, input logic [31:0] b,
                                         input logic [2:0] f, input logic alt, input logic rr);
    logic [4:0] s;
    s = b[4:0];
    case (f)
      3'b000: return (alt && rr) ? a - b : a + b;
      3'b001: return a << s;
      3'b010: return {31'b0, $signed(a) < $signed(b)};
      3'b011: return {31'b0, a < b};
      3'b100: return a ^ b;
      3'b101: return alt ? $unsigned($signed(a) >>> s) : a >> s;
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] f, input logic alt, input logic rr);
    @(posedge clk);
    {opA, opB, funct3, altBit, regForm} = {a, b, f, alt, rr};
    @(negedge clk);
  endtask

  task automatic checkRes(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] f, input logic alt, input logic rr);
    logic [31:0] exp;
    apply(a, b, f, alt, rr);
    exp = refAlu(a, b, f, alt, rr);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s f3=%b alt=%b a=%h b=%h actual=%h expected=%h",
               req, f, alt, a, b, result, exp);
    end
  endtask

  task automatic checkFlags(input logic [31:0] a, input logic [31:0] b);
    logic [2:0] exp;
    apply(a, b, 3'b010, 1'b0, 1'b1);
    exp = {$signed(a) < $signed(b), a < b, a == b};
    checks++;
    if ({lessSigned, lessUnsigned, equal} !== exp) begin
      errors++;
      $display("FAIL R8 a=%h b=%h actual=%b expected=%b", a, b,
               {lessSigned, lessUnsigned, equal}, exp);
    end
  endtask

  task automatic tInitial();
    checkRes("R1", 32'h0, 32'h0, 3'b000, 1'b0, 1'b0);
  endtask

  task automatic tAddSub();
    checkRes("R1", 32'h7FFF_FFFF, 32'h1, 3'b000, 1'b0, 1'b1);
    checkRes("R1", 32'hFFFF_FFFF, 32'h1, 3'b000, 1'b0, 1'b1);
    checkRes("R1", 32'h1234_0000, 32'h5, 3'b000, 1'b1, 1'b0);
    checkRes("R2", 32'h0, 32'h1, 3'b000, 1'b1, 1'b1);
    checkRes("R2", 32'h8000_0000, 32'h1, 3'b000, 1'b1, 1'b1);
  endtask

  task automatic tLogic();
    for (int alt = 0; alt < 2; alt++) begin
      checkRes("R3", 32'hF0F0_1234, 32'hFF00_ABCD, 3'b100, alt[0], 1'b1);
      checkRes("R3", 32'hF0F0_1234, 32'hFF00_ABCD, 3'b110, alt[0], 1'b1);
      checkRes("R3", 32'hF0F0_1234, 32'hFF00_ABCD, 3'b111, alt[0], 1'b1);
    end
  endtask

  task automatic tCompare();
    logic [31:0] v [4] = '{32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        checkRes("R4", v[i], v[j], 3'b010, 1'b0, 1'b1);
        checkRes("R5", v[i], v[j], 3'b011, 1'b0, 1'b1);
        checkFlags(v[i], v[j]);
      end
  endtask

  task automatic tShift();
    for (int s = 0; s < 32; s += 31) begin
      checkRes("R9", 32'h8000_0001, s, 3'b001, 1'b0, 1'b1);
      checkRes("R9", 32'h8000_0001, s, 3'b101, 1'b0, 1'b1);
      checkRes("R9", 32'h8000_0001, s, 3'b101, 1'b1, 1'b1);
    end
    checkRes("R6", 32'h0000_00F1, 32'hFFFF_FFE4, 3'b001, 1'b1, 1'b1);
    checkRes("R7", 32'hF000_0000, 32'h0000_0104, 3'b101, 1'b0, 1'b1);
    checkRes("R7", 32'hF000_0000, 32'h0000_0104, 3'b101, 1'b1, 1'b0);
    checkRes("R7", 32'h7000_0000, 32'h0000_0004, 3'b101, 1'b1, 1'b1);
  endtask

  task automatic tRandom();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [2:0]  f;
      logic        alt, rr;
      a = $urandom; b = $urandom; f = 3'($urandom); alt = 1'($urandom); rr = 1'($urandom);
      if (f == 3'b000) checkRes(alt && rr ? "R2" : "R1", a, b, f, alt, rr);
      else if (f == 3'b001) checkRes("R6", a, b, f, alt, rr);
      else if (f == 3'b101) checkRes("R7", a, b, f, alt, rr);
      else if (f == 3'b010) checkRes("R4", a, b, f, alt, rr);
      else if (f == 3'b011) checkRes("R5", a, b, f, alt, rr);
      else checkRes("R3", a, b, f, alt, rr);
      if (n % 4 == 0) checkFlags(a, b);
    end
  endtask

  initial begin
    {opA, opB, funct3, altBit, regForm} = '0;
    tInitial();
    tAddSub();
    tLogic();
    tCompare();
    tShift();
    tRandom();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule